// File: doc/BRIEF.md
# RS-485 Direction Turnaround Controller

This block drives the direction (driver-enable) line of a half-duplex RS-485 transceiver on behalf of a UART transmitter. When the turnaround mode is on, the line goes to the transmit state as soon as the transmit queue holds data. That happens before the serializer sends the first start bit. The line stays in the transmit state while characters are sent. The line returns to the receive state only after the final stop bit of the final character has been shifted out and a programmable wait of 0 to 15 bit times has run. This wait lets the far end of a long cable see the whole frame before this node releases the bus. If new data is queued during the wait, the wait is abandoned and the line stays in the transmit state.

With the mode off, the direction pin is an ordinary modem-control output that follows a value supplied by the register file. The block also produces the transmit-empty interrupt request. With the mode on, the request waits until both the queue and the shift register have drained. With the mode off, it reports only that the queue is empty. The serializer, the FIFO and the baud generator are outside the block. They supply the status flags, a strobe at the end of each stop bit, and a one-per-bit-time tick.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `dir_out` and `txe_irq` are 0 after that edge.
- R2: With `mode_en` = 0, `dir_out` equals the `modem_out` value sampled at the previous clock edge, whatever `fifo_empty`, `stop_done` and `bit_tick` do.
- R3: With `mode_en` = 1, a clock edge that samples `fifo_empty` = 0 leaves `dir_out` = 1 (1 = transmit, 0 = receive).
- R4: A `stop_done` strobe while `fifo_empty` = 0 does not start a release, and `dir_out` stays 1 however many `bit_tick` pulses follow.
- R5: After a `stop_done` strobe sampled with `fifo_empty` = 1 and `turn_delay` = D, `dir_out` becomes 0 at the edge that samples the D-th `bit_tick` counted after the strobe's edge. With D = 0, it becomes 0 at the strobe's own edge.
- R6: If `fifo_empty` returns to 0 during the turnaround wait, the wait is cancelled and `dir_out` stays 1. A later release again needs a final `stop_done` followed by the full D ticks.
- R7: `bit_tick` pulses that arrive before the final `stop_done` do not shorten the wait.
- R8: With `mode_en` = 1, `txe_irq` one cycle later equals `fifo_empty` AND `tsr_empty`.
- R9: With `mode_en` = 0, `txe_irq` one cycle later equals `fifo_empty`, whatever `tsr_empty` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Turnaround mode enable |
| turn_delay | input | 4 | Wait after the final stop bit, in bit times (0..15) |
| modem_out | input | 1 | Direction value used when the mode is off |
| fifo_empty | input | 1 | Transmit FIFO is empty |
| tsr_empty | input | 1 | Transmit shift register is empty |
| stop_done | input | 1 | One-cycle strobe at the end of each stop bit |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| dir_out | output | 1 | Transceiver direction, 1 = transmit |
| txe_irq | output | 1 | Transmit-empty interrupt request |

## Verification
The hardest case to reach is the exact edge on which the bus is released. Reaching it needs a final stop strobe with an empty queue, followed by exactly D ticks, and no new data in between. Earlier ticks must not leak into the count. The bench sweeps every delay from 0 to 15 under two tick spacings and sends extra ticks before the strobe. It checks the direction after every tick, so an off-by-one error shows at the tick where it happens. A separate sequence queues new data halfway through a wait and then confirms that a fresh full wait is needed.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    ST_RX   = 2'd0,
    ST_TX   = 2'd1,
    ST_HOLD = 2'd2
  } dir_state_t;
endpackage

// File: rtl/rs485_turn_timer.sv
module rs485_turn_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EXT_W-1:0] cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + EXT_W'(1);
  assign done   = tick && (cnt_nx >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (tick && !done) cnt_q <= cnt_nx[CNT_W-1:0];
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/rs485_txe_sel.sv
module rs485_txe_sel (
  input  logic clk,
  input  logic rst,
  input  logic mode_en,
  input  logic fifo_empty,
  input  logic tsr_empty,
  output logic txe_irq
);
  always_ff @(posedge clk) begin
    if (rst) txe_irq <= 1'b0;
    else     txe_irq <= fifo_empty && (tsr_empty || !mode_en);
  end

  // R8
  irq_waits_tsr_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_en && !tsr_empty) |=> !txe_irq);

  // R9
  irq_needs_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (!fifo_empty) |=> !txe_irq);
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_en,
  input  logic [DLY_W-1:0] turn_delay,
  input  logic             modem_out,
  input  logic             fifo_empty,
  input  logic             tsr_empty,
  input  logic             stop_done,
  input  logic             bit_tick,
  output logic             dir_out,
  output logic             txe_irq
);
  import rs485_dir_pkg::*;

  dir_state_t state_q;
  logic       tmr_clr;
  logic       tmr_tick;
  logic       tmr_done;
  logic       last_stop;

  assign last_stop = stop_done && fifo_empty;
  assign tmr_clr   = !mode_en || (state_q != ST_HOLD) || !fifo_empty;
  assign tmr_tick  = bit_tick && (state_q == ST_HOLD) && fifo_empty;

  rs485_turn_timer #(.CNT_W(DLY_W)) timer_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (tmr_clr),
    .tick  (tmr_tick),
    .limit (turn_delay),
    .done  (tmr_done)
  );

  rs485_txe_sel irq_i (
    .clk        (clk),
    .rst        (rst),
    .mode_en    (mode_en),
    .fifo_empty (fifo_empty),
    .tsr_empty  (tsr_empty),
    .txe_irq    (txe_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RX;
      dir_out <= 1'b0;
    end else if (!mode_en) begin
      state_q <= ST_RX;
      dir_out <= modem_out;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (!fifo_empty) begin
            state_q <= ST_TX;
            dir_out <= 1'b1;
          end else begin
            dir_out <= 1'b0;
          end
        end
        ST_TX: begin
          dir_out <= 1'b1;
          if (last_stop) begin
            if (turn_delay == '0) begin
              state_q <= ST_RX;
              dir_out <= 1'b0;
            end else begin
              state_q <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          dir_out <= 1'b1;
          if (!fifo_empty) begin
            state_q <= ST_TX;
          end else if (tmr_done) begin
            state_q <= ST_RX;
            dir_out <= 1'b0;
          end
        end
        default: begin
          state_q <= ST_RX;
          dir_out <= 1'b0;
        end
      endcase
    end
  end

  // R3
  drive_on_data_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_en && !fifo_empty) |=> dir_out);

  // R2
  plain_output_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_en) |=> (dir_out == $past(modem_out)));

  // R5
  release_empty_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_en) && $fell(dir_out)) |-> $past(fifo_empty));

  // R1
  reset_rx_chk: assert property (@(posedge clk)
    rst |=> (!dir_out && !txe_irq));
endmodule

// File: tb/rs485_dir_ctrl_tb.sv
module rs485_dir_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       mode_en;
  logic [3:0] turn_delay;
  logic       modem_out;
  logic       fifo_empty;
  logic       tsr_empty;
  logic       stop_done;
  logic       bit_tick;
  logic       dir_out;
  logic       txe_irq;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  rs485_dir_ctrl #(.DLY_W(4)) dut_i (
    .clk(clk), .rst(rst), .mode_en(mode_en), .turn_delay(turn_delay),
    .modem_out(modem_out), .fifo_empty(fifo_empty), .tsr_empty(tsr_empty),
    .stop_done(stop_done), .bit_tick(bit_tick), .dir_out(dir_out),
    .txe_irq(txe_irq)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick_once(input int gap);
    for (int g = 0; g < gap; g++) step();
    bit_tick = 1'b1;
    step();
    bit_tick = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mode_en = 1'b1; turn_delay = 4'd3; modem_out = 1'b1;
    fifo_empty = 1'b0; tsr_empty = 1'b1; stop_done = 1'b0; bit_tick = 1'b0;
    @(negedge clk);
    step();
    chk("R1 dir", dir_out, 1'b0);
    chk("R1 irq", txe_irq, 1'b0);
    rst = 1'b0;
    fifo_empty = 1'b1;
    step();

    // R5 / R7 / R3 / R8: sweep every delay under two tick spacings
    for (int sp = 0; sp < 2; sp++) begin
      for (int d = 0; d < 16; d++) begin
        turn_delay = 4'(d);
        fifo_empty = 1'b0; tsr_empty = 1'b0;
        step();
        chk("R3", dir_out, 1'b1);
        fifo_empty = 1'b1;
        step();
        chk("R8 busy shifter", txe_irq, 1'b0);
        for (int k = 0; k < 3; k++) tick_once(sp * 2);
        chk("R7 early ticks", dir_out, 1'b1);
        stop_done = 1'b1; tsr_empty = 1'b1;
        step();
        stop_done = 1'b0;
        chk("R5 at stop", dir_out, (d == 0) ? 1'b0 : 1'b1);
        chk("R8 drained", txe_irq, 1'b1);
        for (int k = 1; k <= d; k++) begin
          tick_once(sp * 2);
          chk("R5 tick", dir_out, (k < d) ? 1'b1 : 1'b0);
        end
        step();
        chk("R5 settled", dir_out, 1'b0);
      end
    end

    // R4: stop strobe with data still queued
    turn_delay = 4'd2;
    fifo_empty = 1'b0; tsr_empty = 1'b0;
    step();
    stop_done = 1'b1;
    step();
    stop_done = 1'b0;
    for (int k = 0; k < 20; k++) tick_once(0);
    chk("R4", dir_out, 1'b1);

    // R6: cancel mid-wait, then a fresh full wait
    turn_delay = 4'd5;
    fifo_empty = 1'b1;
    stop_done = 1'b1;
    step();
    stop_done = 1'b0;
    tick_once(0);
    tick_once(1);
    chk("R6 waiting", dir_out, 1'b1);
    fifo_empty = 1'b0;
    step();
    chk("R6 cancel", dir_out, 1'b1);
    for (int k = 0; k < 10; k++) tick_once(0);
    chk("R6 stays tx", dir_out, 1'b1);
    fifo_empty = 1'b1;
    step();
    for (int k = 0; k < 4; k++) tick_once(0);
    chk("R6 no stop yet", dir_out, 1'b1);
    stop_done = 1'b1;
    step();
    stop_done = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      tick_once(0);
      chk("R6 fresh wait", dir_out, (k < 5) ? 1'b1 : 1'b0);
    end

    // R2 / R9: mode off
    mode_en = 1'b0;
    for (int v = 0; v < 16; v++) begin
      modem_out  = v[0];
      fifo_empty = v[1];
      stop_done  = v[2];
      bit_tick   = v[3];
      tsr_empty  = ~v[2];
      step();
      chk("R2", dir_out, v[0]);
      chk("R9", txe_irq, v[1]);
    end
    stop_done = 1'b0; bit_tick = 1'b0;

    // R8 full table with mode on
    mode_en = 1'b1;
    for (int v = 0; v < 4; v++) begin
      fifo_empty = v[0];
      tsr_empty  = v[1];
      step();
      chk("R8 table", txe_irq, v[0] & v[1]);
    end

    // R1: reset from transmit state
    fifo_empty = 1'b0;
    step();
    rst = 1'b1;
    step();
    chk("R1 dir after tx", dir_out, 1'b0);
    chk("R1 irq after tx", txe_irq, 1'b0);
    rst = 1'b0;

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule